// File: doc/BRIEF.md
# Threshold Alarm Peripheral with Memory-Mapped Registers

This block sits on a simple synchronous processor bus and answers a window of four 16-bit registers above a base address. It watches seven 8-bit sample inputs. Each sample is compared against one programmable threshold. When an enabled port's sample goes strictly above that threshold, an alarm flag for that port is latched. While any alarm is latched and interrupts are enabled, the interrupt request is held high.

Software can also ask for a single port's sample through a command. Writing a read request to the command register drops the ready indication for a fixed number of cycles. When that time has passed, the selected sample is placed in the data register and ready rises again. A driver therefore polls ready, writes the command, polls ready again, and then reads the data register. Reading the status register acknowledges every latched alarm at once.

The register window is found by address decode. The word address bits above bit 2 must equal those of the base, byte address bit 0 must be zero, and the address-space select input must equal the space the block is mapped into. Byte address bits 2:1 then choose the register: 0 is configuration, 1 is status, 2 is command and 3 is data. Read data is registered.

Top module: `thr_alarm_periph`

## Requirements
- R1: After a synchronous reset with `rst_n` low, configuration and data read as 0, status reads 0x0002 (ready set), `irq` is 0, `alarm` is 0 and `bus_rdata` is 0.
- R2: An access is taken only when `bus_addr[15:3]` equals `BASE_ADDR[15:3]`, `bus_addr[0]` is 0 and `bus_space` equals `MAP_SPACE` (default 1). Any other access returns 0 on `bus_rdata` and changes no register.
- R3: The configuration register (byte offset 0) is read/write. Bit 0 is the interrupt enable, bit k (k = 1..7) is the alarm enable for port k, and bits 15:8 hold the threshold. A write reads back unchanged.
- R4: The status register (byte offset 2) reads bit 0 = interrupt enable, bit 1 = ready, and bits 15:2 = 0. Writes to it are ignored.
- R5: Read data appears on `bus_rdata` in the cycle after the read strobe. In any cycle that does not follow a decoded read strobe, `bus_rdata` is 0.
- R6: A write to the command register (byte offset 4) is valid when bit 15 is 1, bits 2:0 hold a port number from 1 to 7, and ready is set. A valid write clears ready for exactly `BUSY_CYCLES` clock cycles (default 8).
- R7: When ready rises after a valid command, the data register (byte offset 6) holds {8'h00, sample of the selected port}. Port k's sample is `port_samples[8k-1:8k-8]`.
- R8: A command write with bit 15 clear or a port number of 0 leaves ready and data unchanged. So does any command written while ready is clear; the command in progress finishes on its original schedule.
- R9: Alarm bit k-1 latches when alarm enable k is set and port k's sample is strictly greater than the threshold. A sample equal to the threshold, or a disabled port, sets nothing. A latched alarm stays set after the sample falls.
- R10: A decoded read of the status register clears all latched alarms. If an alarm condition is still true on that same cycle, that alarm stays set.
- R11: `irq` is 1 exactly when at least one alarm is latched and the interrupt enable is 1. Clearing the enable lowers `irq` without clearing the alarms.
- R12: Writes to the data register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_space | input | 1 | Address-space select, compared with `MAP_SPACE` |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data, valid the cycle after `bus_rd` |
| port_samples | input | 56 | Seven 8-bit samples, port k in bits 8k-1:8k-8 |
| alarm | output | 7 | Latched alarms, bit k-1 for port k |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume the bus never raises write and read in the same cycle. They also assume the samples are synchronous to `clk` and stable around each edge. The bench drives every input at the falling edge and issues at most one strobe per access, so both conditions hold. The command and alarm checks rely on each sample staying constant between the bench's explicit changes. The stimulus only changes a sample while no command is in flight, or changes it on purpose to test the alarm latch.

// File: rtl/thr_alarm_pkg.sv
// Package: shared constants and types for the threshold alarm peripheral.
// Assumes a fixed register layout: 16-bit registers, seven 8-bit ports.
package thr_alarm_pkg;

    localparam int REG_W     = 16;
    localparam int NUM_PORTS = 7;
    localparam int SAMPLE_W  = 8;
    localparam int THR_LSB   = REG_W - SAMPLE_W;
    localparam int REQ_BIT   = REG_W - 1;
    localparam int PORT_W    = $clog2(NUM_PORTS + 1);

    // Register index taken from byte address bits 2:1
    typedef enum logic [1:0] {
        IDX_CFG  = 2'd0,
        IDX_STAT = 2'd1,
        IDX_CMD  = 2'd2,
        IDX_DATA = 2'd3
    } reg_idx_e;

    // Build the status word from interrupt enable and ready
    function automatic logic [REG_W-1:0] status_word(input logic ie, input logic rdy);
        status_word = {{(REG_W-2){1'b0}}, rdy, ie};
    endfunction

endpackage

// File: rtl/thr_alarm_decode.sv
// Module: address recognition for the four-register window.
// Produces a device select and the register index. A hit needs the
// matching word address, an even byte address and the mapped space.
// Assumes ADDR_W >= 4 and at most one strobe per cycle.
module thr_alarm_decode
    import thr_alarm_pkg::*;
#(
    parameter int               ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFC00,
    parameter logic             MAP_SPACE = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              space,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_hit,
    output logic              rd_hit,
    output reg_idx_e          idx
);

    logic dev_sel;

    // Compare window, byte alignment and address space
    always_comb begin
        dev_sel = (addr[ADDR_W-1:3] == BASE_ADDR[ADDR_W-1:3])
               && (addr[0] == 1'b0)
               && (space == MAP_SPACE);
        idx     = reg_idx_e'(addr[2:1]);
        wr_hit  = dev_sel && wr;
        rd_hit  = dev_sel && rd;
    end

endmodule

// File: rtl/thr_alarm_cmd.sv
// Module: command engine. A valid read request clears ready, counts
// BUSY_CYCLES clocks, then loads the selected port's sample into the
// data register and sets ready again. Commands that are invalid or
// arrive while busy are dropped. Assumes BUSY_CYCLES >= 1.
module thr_alarm_cmd
    import thr_alarm_pkg::*;
#(
    parameter int BUSY_CYCLES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmd_wr,
    input  logic                          cmd_req,
    input  logic [PORT_W-1:0]             cmd_port,
    input  logic [NUM_PORTS*SAMPLE_W-1:0] samples,
    output logic                          ready,
    output logic [REG_W-1:0]              data_q
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic [CNT_W-1:0]    cnt;
    logic [PORT_W-1:0]   port_q;
    logic [SAMPLE_W-1:0] picked;
    logic                cmd_ok;
    logic                start;
    logic                done;

    // Accept only request commands that name an existing port while idle
    always_comb begin
        cmd_ok = cmd_req && (cmd_port != '0) && (int'(cmd_port) <= NUM_PORTS);
        start  = cmd_wr && ready && cmd_ok;
        done   = !ready && (cnt == CNT_W'(1));
    end

    // Select the latched port's sample
    always_comb begin
        picked = '0;
        for (int k = 0; k < NUM_PORTS; k++) begin
            if (port_q == PORT_W'(k + 1)) picked = samples[k*SAMPLE_W +: SAMPLE_W];
        end
    end

    // Busy counter, ready flag and data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            port_q <= '0;
            ready  <= 1'b1;
            data_q <= '0;
        end else if (start) begin
            cnt    <= CNT_W'(BUSY_CYCLES);
            port_q <= cmd_port;
            ready  <= 1'b0;
        end else if (done) begin
            cnt    <= '0;
            ready  <= 1'b1;
            data_q <= {{(REG_W-SAMPLE_W){1'b0}}, picked};
        end else if (!ready) begin
            cnt    <= cnt - CNT_W'(1);
        end
    end

    // R6: a taken command drops ready on the next cycle
    a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ready);

    // R6: ready only returns once the count has run out
    a_r6_ready_rise_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(cnt) == CNT_W'(1)));

    // R7, R8, R12: data changes only at command completion
    a_r7_data_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(data_q));

endmodule

// File: rtl/thr_alarm_bank.sv
// Module: per-port alarm latches. A port's alarm is set while it is
// enabled and its sample is strictly above the threshold. All alarms
// clear on clr, but a condition true on that cycle still sets its alarm.
// Assumes samples are synchronous to clk.
module thr_alarm_bank
    import thr_alarm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS*SAMPLE_W-1:0] samples,
    input  logic [NUM_PORTS-1:0]          en,
    input  logic [SAMPLE_W-1:0]           thr,
    input  logic                          clr,
    output logic [NUM_PORTS-1:0]          alarm_q
);

    logic [NUM_PORTS-1:0] over;

    // One comparator per port
    for (genvar k = 0; k < NUM_PORTS; k++) begin : g_cmp
        assign over[k] = en[k] && (samples[k*SAMPLE_W +: SAMPLE_W] > thr);
    end

    // Latch, with set taking priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n) alarm_q <= '0;
        else        alarm_q <= (clr ? '0 : alarm_q) | over;
    end

    // R9: a latched alarm holds unless cleared
    a_r9_alarm_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ((alarm_q & $past(alarm_q)) == $past(alarm_q)));

    // R9, R10: a true condition always sets its alarm
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((alarm_q & $past(over)) == $past(over)));

endmodule

// File: rtl/thr_alarm_periph.sv
// Module: top of the threshold alarm peripheral. Holds the configuration
// register and the registered read path, and joins decode, command engine
// and alarm bank. Assumes write and read strobes are never raised together.
module thr_alarm_periph
    import thr_alarm_pkg::*;
#(
    parameter int                ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR   = 16'hFC00,
    parameter logic              MAP_SPACE   = 1'b1,
    parameter int                BUSY_CYCLES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic                          bus_space,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [REG_W-1:0]              bus_wdata,
    output logic [REG_W-1:0]              bus_rdata,
    input  logic [NUM_PORTS*SAMPLE_W-1:0] port_samples,
    output logic [NUM_PORTS-1:0]          alarm,
    output logic                          irq
);

    logic              wr_hit;
    logic              rd_hit;
    reg_idx_e          idx;
    logic [REG_W-1:0]  cfg_q;
    logic [REG_W-1:0]  data_q;
    logic              ready;
    logic              ie;
    logic              stat_rd;

    thr_alarm_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR),
        .MAP_SPACE (MAP_SPACE)
    ) u_decode (
        .addr   (bus_addr),
        .space  (bus_space),
        .wr     (bus_wr),
        .rd     (bus_rd),
        .wr_hit (wr_hit),
        .rd_hit (rd_hit),
        .idx    (idx)
    );

    // Configuration fields and status-read acknowledge
    always_comb begin
        ie      = cfg_q[0];
        stat_rd = rd_hit && (idx == IDX_STAT);
    end

    // Configuration register, written only through a decoded access
    always_ff @(posedge clk) begin
        if (!rst_n)                            cfg_q <= '0;
        else if (wr_hit && (idx == IDX_CFG))   cfg_q <= bus_wdata;
    end

    thr_alarm_cmd #(
        .BUSY_CYCLES (BUSY_CYCLES)
    ) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_wr   (wr_hit && (idx == IDX_CMD)),
        .cmd_req  (bus_wdata[REQ_BIT]),
        .cmd_port (bus_wdata[PORT_W-1:0]),
        .samples  (port_samples),
        .ready    (ready),
        .data_q   (data_q)
    );

    thr_alarm_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .samples (port_samples),
        .en      (cfg_q[NUM_PORTS:1]),
        .thr     (cfg_q[REG_W-1:THR_LSB]),
        .clr     (stat_rd),
        .alarm_q (alarm)
    );

    // Registered read data, zero when no decoded read was made
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_hit) begin
            unique case (idx)
                IDX_CFG:  bus_rdata <= cfg_q;
                IDX_STAT: bus_rdata <= status_word(ie, ready);
                IDX_CMD:  bus_rdata <= '0;
                IDX_DATA: bus_rdata <= data_q;
            endcase
        end else begin
            bus_rdata <= '0;
        end
    end

    assign irq = ie && (|alarm);

    // R2, R3: configuration moves only on a decoded configuration write
    a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && (idx == IDX_CFG)) |=> $stable(cfg_q));

    // R5: read data returns to zero when no decoded read was made
    a_r5_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> (bus_rdata == '0));

    // R4: upper status bits read as zero
    a_r4_status_upper: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (bus_rdata[REG_W-1:2] == '0));

    // R11: no interrupt while the enable is clear
    a_r11_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[0] == 1'b0) |-> !irq);

endmodule

// File: tb/thr_alarm_periph_bench.sv
// Bench: a table walk of command words, then directed tests for reset,
// decode, register access and the alarm latch.
module thr_alarm_periph_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          BUSY       = 8;
    localparam logic [15:0] BASE       = 16'hFC00;
    localparam logic [15:0] A_CFG      = BASE;
    localparam logic [15:0] A_STAT     = BASE + 16'd2;
    localparam logic [15:0] A_CMD      = BASE + 16'd4;
    localparam logic [15:0] A_DATA     = BASE + 16'd6;

    // {expected port (0 = ignored), command word}
    localparam logic [18:0] VEC [8] = '{
        {3'd1, 16'h8001}, {3'd0, 16'h8000}, {3'd0, 16'h0003}, {3'd7, 16'h8007},
        {3'd5, 16'hFFF5}, {3'd0, 16'h8008}, {3'd0, 16'h7FFF}, {3'd2, 16'h800A}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_space = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [55:0] port_samples = '0;
    logic [6:0]  alarm;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thr_alarm_periph #(.BUSY_CYCLES(BUSY)) u_thr_alarm_periph (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_space(bus_space),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .port_samples(port_samples),
        .alarm(alarm), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic sp, input logic [15:0] d);
        bus_addr = a; bus_space = sp; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_space = 1'b1;
    endtask

    task automatic rd_reg(input logic [15:0] a, input logic sp, output logic [15:0] v);
        bus_addr = a; bus_space = sp; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_space = 1'b1;
        v = bus_rdata;
    endtask

    function automatic logic [7:0] smp(input int k);
        smp = port_samples[(k-1)*8 +: 8];
    endfunction

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] last_data;
        for (int k = 1; k <= 7; k++) port_samples[(k-1)*8 +: 8] = 8'(8'h11 * k);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 irq", {15'd0, irq}, 16'd0);
        check("R1 alarm", {9'd0, alarm}, 16'd0);
        check("R1 rdata", bus_rdata, 16'd0);
        rd_reg(A_CFG, 1'b1, v);  check("R1 cfg", v, 16'h0000);
        rd_reg(A_STAT, 1'b1, v); check("R1 status", v, 16'h0002);
        rd_reg(A_DATA, 1'b1, v); check("R1 data", v, 16'h0000);
        @(negedge clk);
        check("R5 rdata idle after read", bus_rdata, 16'h0000);
        last_data = 16'h0000;

        // R6, R7, R8: table of command words
        for (int i = 0; i < 8; i++) begin
            int p;
            p = int'(VEC[i][18:16]);
            wr_reg(A_CMD, 1'b1, VEC[i][15:0]);
            bus_addr = A_STAT; bus_rd = 1'b1;
            for (int c = 1; c <= BUSY + 1; c++) begin
                @(negedge clk);
                if (p != 0) check("R6 ready window", {15'd0, bus_rdata[1]}, {15'd0, c > BUSY});
                else        check("R8 ready kept", {15'd0, bus_rdata[1]}, 16'd1);
            end
            bus_rd = 1'b0;
            if (p != 0) last_data = {8'h00, smp(p)};
            rd_reg(A_DATA, 1'b1, v);
            check(p != 0 ? "R7 data" : "R8 data kept", v, last_data);
        end

        // R8: second command while busy does not restart or replace
        wr_reg(A_CMD, 1'b1, 16'h8002);
        wr_reg(A_CMD, 1'b1, 16'h8003);
        bus_addr = A_STAT; bus_rd = 1'b1;
        for (int c = 2; c <= BUSY + 1; c++) begin
            @(negedge clk);
            check("R8 busy ignore timing", {15'd0, bus_rdata[1]}, {15'd0, c > BUSY});
        end
        bus_rd = 1'b0;
        rd_reg(A_DATA, 1'b1, v); check("R8 busy ignore data", v, {8'h00, smp(2)});
        last_data = v;

        // R12: data register writes ignored
        wr_reg(A_DATA, 1'b1, 16'hBEEF);
        rd_reg(A_DATA, 1'b1, v); check("R12 data write ignored", v, last_data);

        // R3, R4: configuration readback and status fields
        wr_reg(A_CFG, 1'b1, 16'hFF0E);
        rd_reg(A_CFG, 1'b1, v);  check("R3 cfg readback", v, 16'hFF0E);
        rd_reg(A_STAT, 1'b1, v); check("R4 status ie off", v, 16'h0002);
        wr_reg(A_CFG, 1'b1, 16'hFF0F);
        rd_reg(A_STAT, 1'b1, v); check("R4 status ie on", v, 16'h0003);
        wr_reg(A_STAT, 1'b1, 16'hFFFC);
        rd_reg(A_STAT, 1'b1, v); check("R4 status write ignored", v, 16'h0003);
        wr_reg(A_CFG, 1'b1, 16'h0000);

        // R2: decode rejects wrong space, out-of-window and odd addresses
        wr_reg(A_CFG, 1'b0, 16'h1234);
        wr_reg(BASE + 16'd8, 1'b1, 16'h5678);
        wr_reg(BASE + 16'd1, 1'b1, 16'h9ABC);
        rd_reg(A_CFG, 1'b1, v); check("R2 stray writes ignored", v, 16'h0000);
        wr_reg(A_CFG, 1'b1, 16'hA501);
        rd_reg(A_CFG, 1'b0, v); check("R2 wrong space read", v, 16'h0000);
        rd_reg(BASE - 16'd2, 1'b1, v); check("R2 below window read", v, 16'h0000);
        rd_reg(A_CFG, 1'b1, v); check("R2 R3 decoded read", v, 16'hA501);
        wr_reg(A_CFG, 1'b1, 16'h0000);
        rd_reg(A_STAT, 1'b1, v);

        // R9: threshold 0x40, port 3 enabled, interrupts on
        wr_reg(A_CFG, 1'b1, 16'h4009);
        port_samples[2*8 +: 8] = 8'h40;
        @(negedge clk); @(negedge clk);
        check("R9 equal and disabled no alarm", {9'd0, alarm}, 16'd0);
        check("R11 no irq", {15'd0, irq}, 16'd0);
        port_samples[2*8 +: 8] = 8'h41;
        @(negedge clk);
        check("R9 alarm set", {9'd0, alarm}, 16'h0004);
        check("R11 irq set", {15'd0, irq}, 16'd1);
        port_samples[2*8 +: 8] = 8'h10;
        @(negedge clk); @(negedge clk);
        check("R9 alarm held", {9'd0, alarm}, 16'h0004);
        wr_reg(A_CFG, 1'b1, 16'h4008);
        check("R11 irq gated", {15'd0, irq}, 16'd0);
        check("R11 alarm kept", {9'd0, alarm}, 16'h0004);
        wr_reg(A_CFG, 1'b1, 16'h4009);
        check("R11 irq back", {15'd0, irq}, 16'd1);

        // R10: status read clears, unless the condition persists
        rd_reg(A_STAT, 1'b1, v);
        check("R10 status value", v, 16'h0003);
        check("R10 alarm cleared", {9'd0, alarm}, 16'd0);
        check("R10 irq cleared", {15'd0, irq}, 16'd0);
        port_samples[2*8 +: 8] = 8'h50;
        @(negedge clk);
        rd_reg(A_STAT, 1'b1, v);
        check("R10 set wins over clear", {9'd0, alarm}, 16'h0004);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule